// File: doc/BRIEF.md
# Receive Byte-Lane Threshold FIFO

This block sits between a byte-serial receive path and a 16-bit or 32-bit system bus master. Received bytes arrive one per cycle with a valid strobe and an end-of-packet strobe. Each byte goes into one lane of a 4-byte-wide array, and the selected byte order decides the lane. Little-endian order fills the least significant lane of a row first. Big-endian order fills the most significant lane first. The array holds eight rows.

A programmable threshold decides when the block asks the bus master for service. The block raises `dma_req` once the number of buffered bytes is strictly greater than the threshold. The master answers with a one-cycle `dma_gnt`. The block then presents one bus unit per cycle on `out_data` while `out_valid` is high. A bus unit is a 16-bit half row in 16-bit mode or a whole row in 32-bit mode. The burst size depends on the mode. In block mode a burst is exactly the threshold amount. In empty/fill mode a burst is every complete unit held.

At end of packet, the block fills the unused bytes of the last unit with 0xFF. It then places a packet status unit directly behind the data. It also keeps requesting service until that tail has been drained, even when the count is at or below the threshold.

Top module: `rx_lane_fifo`

## Requirements
- R1: After reset, `dma_req`, `out_valid` and `ovf_flag` are low.
- R2: Bytes of a packet come out in arrival order, grouped by bus unit (16 bits when `cfg_bus32`=0, 32 bits when it is 1).
  - With `cfg_big_endian`=0, the first byte of a unit is its least significant byte.
  - With `cfg_big_endian`=1, the first byte of a unit is its most significant byte.
  - In 16-bit mode, `out_data[31:16]` is zero.
- R3: The threshold code `cfg_thr_code` (0..3) selects the threshold in units.
  - In 16-bit mode it selects 2, 4, 8 or 12 words.
  - In 32-bit mode it selects 2, 4, 6 or 7 long words.
  - Outside an end-of-packet flush, `dma_req` is high only when the buffered byte count exceeds the threshold in bytes. For example, with threshold T bytes, T bytes give no request and T+1 bytes do.
- R4: In block mode (`cfg_empty_fill`=0), a grant taken above threshold yields a burst of exactly the threshold in units. If the count is still above threshold when the burst ends, `dma_req` is high again in the very next cycle.
- R5: In empty/fill mode (`cfg_empty_fill`=1), one grant yields a burst of every complete unit held at grant time.
- R6: When the end-of-packet byte does not complete a unit, the remaining bytes of that unit read as 0xFF.
- R7: The unit right after a packet's last data unit is its status. In 32-bit mode this is `in_status`. In 16-bit mode it is `in_status[15:0]`.
- R8: Once an end-of-packet byte is accepted, `dma_req` stays asserted until every complete unit has been drained. It then stays low until new data arrives.
- R9: A byte, or an end-of-packet byte together with its padding and status, is dropped if it does not fit in the 32 bytes. The drop sets `ovf_flag`, which stays high until reset.
- R10: `dma_req` is low while a burst is in progress. A grant while `dma_req` is low starts no burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bus32 | input | 1 | 1: 32-bit bus units, 0: 16-bit bus units |
| cfg_big_endian | input | 1 | 1: first byte to the most significant lane |
| cfg_thr_code | input | 2 | Threshold selector |
| cfg_empty_fill | input | 1 | 1: empty/fill bursts, 0: block bursts |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| in_eop | input | 1 | This byte ends the packet |
| in_status | input | 32 | Packet status, taken with the end-of-packet byte |
| dma_req | output | 1 | Service request toward the bus master |
| dma_gnt | input | 1 | One-cycle grant that starts a burst |
| out_valid | output | 1 | A bus unit is presented this cycle |
| out_data | output | 32 | Bus unit (16-bit units in bits 15:0) |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
A byte is sampled at a rising edge and updates the registered count at that edge. Because `dma_req` is decoded from registered state, a byte's effect on the request is visible in the same cycle, just after that edge. A grant sampled at an edge loads the burst counter. The first unit is therefore on `out_data` in the following cycle, and later units follow one per cycle with no gaps. After the last unit, `out_valid` drops and the renewed request, if any, shows in that same cycle. The bench drives inputs and samples outputs on falling edges. Each check falls in the half cycle after the edge that produced the result, so every expected value is counted in whole cycles from the stimulus.

// File: rtl/rx_lane_pkg.sv
package rx_lane_pkg;

    localparam int LANES = 4;

    typedef enum logic {
        ORD_LITTLE = 1'b0,
        ORD_BIG    = 1'b1
    } order_e;

    // Lane in a row that holds the byte at row offset off.
    function automatic logic [1:0] lane_for(input logic [1:0] off, input order_e ord);
        return (ord == ORD_BIG) ? (2'd3 - off) : off;
    endfunction

    // Half row that holds the 16-bit unit starting at row offset off.
    function automatic logic half_for(input logic [1:0] off, input order_e ord);
        return (ord == ORD_BIG) ? ~off[1] : off[1];
    endfunction

endpackage

// File: rtl/rx_thresh_decode.sv
module rx_thresh_decode #(
    parameter int CW = 6
) (
    input  logic          bus32,
    input  logic [1:0]    code,
    output logic [CW-1:0] thr_units,
    output logic [CW-1:0] thr_bytes
);
    always_comb begin
        if (bus32) begin
            case (code)
                2'd0:    thr_units = CW'(2);
                2'd1:    thr_units = CW'(4);
                2'd2:    thr_units = CW'(6);
                default: thr_units = CW'(7);
            endcase
            thr_bytes = thr_units << 2;
        end else begin
            case (code)
                2'd0:    thr_units = CW'(2);
                2'd1:    thr_units = CW'(4);
                2'd2:    thr_units = CW'(8);
                default: thr_units = CW'(12);
            endcase
            thr_bytes = thr_units << 1;
        end
    end
endmodule

// File: rtl/rx_lane_store.sv
module rx_lane_store
    import rx_lane_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic [ENTRIES*LANES-1:0]                    wr_mask,
    input  logic [ENTRIES*LANES-1:0][7:0]               wr_data,
    input  logic [$clog2(ENTRIES*LANES)-1:0]            rd_pos,
    input  logic                                        bus32,
    input  order_e                                      ord,
    output logic [31:0]                                 rd_data
);
    localparam int BYTES = ENTRIES * LANES;
    localparam int PW    = $clog2(BYTES);

    logic [BYTES-1:0][7:0] mem_d, mem_q;
    logic [PW-3:0]         row;
    logic                  half;

    always_comb begin
        mem_d = mem_q;
        for (int i = 0; i < BYTES; i++) begin
            if (wr_mask[i]) mem_d[i] = wr_data[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '0;
        else        mem_q <= mem_d;
    end

    always_comb begin
        row  = rd_pos[PW-1:2];
        half = half_for(rd_pos[1:0], ord);
        if (bus32) begin
            rd_data = {mem_q[{row, 2'd3}], mem_q[{row, 2'd2}],
                       mem_q[{row, 2'd1}], mem_q[{row, 2'd0}]};
        end else begin
            rd_data = {16'h0000, mem_q[{row, half, 1'b1}], mem_q[{row, half, 1'b0}]};
        end
    end
endmodule

// File: rtl/rx_lane_fifo.sv
module rx_lane_fifo
    import rx_lane_pkg::*;
#(
    parameter int ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_bus32,
    input  logic        cfg_big_endian,
    input  logic [1:0]  cfg_thr_code,
    input  logic        cfg_empty_fill,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_eop,
    input  logic [31:0] in_status,
    output logic        dma_req,
    input  logic        dma_gnt,
    output logic        out_valid,
    output logic [31:0] out_data,
    output logic        ovf_flag
);
    localparam int BYTES = ENTRIES * LANES;
    localparam int PW    = $clog2(BYTES);
    localparam int CW    = PW + 1;

    typedef struct packed {
        logic [PW-1:0] wpos;
        logic [PW-1:0] rpos;
        logic [CW-1:0] count;
        logic [CW-1:0] left;
        logic          flush;
        logic          ovf;
    } state_t;

    state_t st_d, st_q;

    order_e                 ord;
    logic [CW-1:0]          thr_units, thr_bytes;
    logic [CW-1:0]          ubytes, units_held, need, free_b, len;
    logic [1:0]             off, umask, pad;
    logic                   busy, accept;
    logic [BYTES-1:0]       wr_mask;
    logic [BYTES-1:0][7:0]  wr_data;
    logic [PW-1:0]          spos;
    logic                   shalf;

    assign ord = order_e'(cfg_big_endian);

    rx_thresh_decode #(.CW(CW)) u_thr (
        .bus32     (cfg_bus32),
        .code      (cfg_thr_code),
        .thr_units (thr_units),
        .thr_bytes (thr_bytes)
    );

    rx_lane_store #(.ENTRIES(ENTRIES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_mask (wr_mask),
        .wr_data (wr_data),
        .rd_pos  (st_q.rpos),
        .bus32   (cfg_bus32),
        .ord     (ord),
        .rd_data (out_data)
    );

    assign ubytes     = cfg_bus32 ? CW'(4) : CW'(2);
    assign units_held = cfg_bus32 ? (st_q.count >> 2) : (st_q.count >> 1);
    assign busy       = (st_q.left != '0);
    assign dma_req    = !busy && ((st_q.count > thr_bytes) ||
                                  (st_q.flush && units_held != '0));
    assign out_valid  = busy;
    assign ovf_flag   = st_q.ovf;

    assign off    = st_q.wpos[1:0];
    assign umask  = cfg_bus32 ? 2'b11 : 2'b01;
    assign pad    = umask - (off & umask);
    assign need   = in_eop ? (CW'(1) + CW'(pad) + ubytes) : CW'(1);
    assign free_b = CW'(BYTES) - st_q.count;
    assign accept = in_valid && (need <= free_b);
    assign len    = (!cfg_empty_fill && st_q.count > thr_bytes) ? thr_units : units_held;

    always_comb begin
        st_d    = st_q;
        wr_mask = '0;
        wr_data = '0;
        spos    = st_q.wpos + PW'(pad) + PW'(1);
        shalf   = half_for(spos[1:0], ord);

        if (in_valid && !accept) st_d.ovf = 1'b1;

        if (accept) begin
            for (int j = 0; j < LANES; j++) begin
                if ((3'(j) == {1'b0, off}) ||
                    (in_eop && 3'(j) > {1'b0, off} && 3'(j) <= ({1'b0, off} + {1'b0, pad}))) begin
                    wr_mask[{st_q.wpos[PW-1:2], lane_for(2'(j), ord)}] = 1'b1;
                    wr_data[{st_q.wpos[PW-1:2], lane_for(2'(j), ord)}] =
                        (3'(j) == {1'b0, off}) ? in_data : 8'hFF;
                end
            end
            if (in_eop) begin
                if (cfg_bus32) begin
                    for (int l = 0; l < LANES; l++) begin
                        wr_mask[{spos[PW-1:2], 2'(l)}] = 1'b1;
                        wr_data[{spos[PW-1:2], 2'(l)}] = in_status[8*l +: 8];
                    end
                end else begin
                    wr_mask[{spos[PW-1:2], shalf, 1'b0}] = 1'b1;
                    wr_data[{spos[PW-1:2], shalf, 1'b0}] = in_status[7:0];
                    wr_mask[{spos[PW-1:2], shalf, 1'b1}] = 1'b1;
                    wr_data[{spos[PW-1:2], shalf, 1'b1}] = in_status[15:8];
                end
            end
            st_d.wpos = st_q.wpos + need[PW-1:0];
        end

        st_d.count = st_q.count + (accept ? need : '0) - (busy ? ubytes : '0);

        if (busy) begin
            st_d.rpos = st_q.rpos + ubytes[PW-1:0];
            st_d.left = st_q.left - CW'(1);
        end

        if (dma_gnt && dma_req) begin
            st_d.left = len;
            if (len == units_held) st_d.flush = 1'b0;
        end

        if (accept && in_eop) st_d.flush = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R10
    no_req_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !dma_req);

    // R9
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R9
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= CW'(BYTES));

    // R4
    block_burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_gnt && dma_req && !cfg_empty_fill && (st_q.count > thr_bytes))
        |=> (out_valid && st_q.left == thr_units));

    // R3
    req_above_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !st_q.flush) |-> (st_q.count > thr_bytes));

endmodule

// File: tb/rx_lane_fifo_test.sv
module rx_lane_fifo_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bus32 = 1'b0, cfg_big_endian = 1'b0, cfg_empty_fill = 1'b0;
    logic [1:0]  cfg_thr_code = 2'd0;
    logic        in_valid = 1'b0, in_eop = 1'b0, dma_gnt = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic [31:0] in_status = '0;
    logic        dma_req, out_valid, ovf_flag;
    logic [31:0] out_data;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [7:0]  pkt [64];
    logic [31:0] got_q [$];
    logic [31:0] exp_q [$];

    rx_lane_fifo uut (
        .clk(clk), .rst_n(rst_n), .cfg_bus32(cfg_bus32), .cfg_big_endian(cfg_big_endian),
        .cfg_thr_code(cfg_thr_code), .cfg_empty_fill(cfg_empty_fill),
        .in_valid(in_valid), .in_data(in_data), .in_eop(in_eop), .in_status(in_status),
        .dma_req(dma_req), .dma_gnt(dma_gnt), .out_valid(out_valid),
        .out_data(out_data), .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic apply_cfg(input bit b32, input bit big, input logic [1:0] code, input bit ef);
        in_valid = 1'b0; in_eop = 1'b0; dma_gnt = 1'b0; rst_n = 1'b0;
        cfg_bus32 = b32; cfg_big_endian = big; cfg_thr_code = code; cfg_empty_fill = ef;
        got_q.delete(); exp_q.delete();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] d, input bit eop, input logic [31:0] st);
        in_valid = 1'b1; in_data = d; in_eop = eop; in_status = st;
        @(negedge clk);
        in_valid = 1'b0; in_eop = 1'b0;
    endtask

    task automatic burst(output int n);
        dma_gnt = 1'b1;
        @(negedge clk);
        dma_gnt = 1'b0;
        n = 0;
        while (out_valid && n < 64) begin
            got_q.push_back(out_data);
            if (dma_req) chk("R10", "request during burst", 32'(dma_req), 32'd0);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic build_exp(input int len, input bit b32, input bit big, input logic [31:0] st);
        int ub;
        ub = b32 ? 4 : 2;
        for (int k = 0; k < len; k += ub) begin
            logic [7:0] b [4];
            for (int j = 0; j < 4; j++) b[j] = (j < ub && k + j < len) ? pkt[k + j] : 8'hFF;
            if (b32) exp_q.push_back(big ? {b[0], b[1], b[2], b[3]} : {b[3], b[2], b[1], b[0]});
            else     exp_q.push_back(big ? {16'h0, b[0], b[1]} : {16'h0, b[1], b[0]});
        end
        exp_q.push_back(b32 ? st : {16'h0, st[15:0]});
    endtask

    initial begin
        int n;
        // Sweep every mode, order, bus width and threshold code
        for (int cfg = 0; cfg < 32; cfg++) begin
            bit b32, big, ef;
            logic [1:0] code;
            int tu, ub, tb, tail, len, nexp;
            logic [31:0] st;
            b32 = cfg[0]; big = cfg[1]; code = 2'(cfg >> 2); ef = cfg[4];
            case (code)
                2'd0: tu = 2;
                2'd1: tu = 4;
                2'd2: tu = b32 ? 6 : 8;
                default: tu = b32 ? 7 : 12;
            endcase
            ub = b32 ? 4 : 2;
            tb = tu * ub;
            tail = 1 + int'(code);
            len = tb + 1 + tail;
            st = 32'hA5C30000 | 32'(cfg * 257 + 9);
            for (int i = 0; i < len; i++) pkt[i] = 8'(i * 37 + cfg * 11 + 3);

            apply_cfg(b32, big, code, ef);
            chk("R1", "dma_req after reset", 32'(dma_req), 32'd0);
            chk("R1", "out_valid after reset", 32'(out_valid), 32'd0);
            chk("R1", "ovf_flag after reset", 32'(ovf_flag), 32'd0);

            for (int i = 0; i < tb; i++) send(pkt[i], 1'b0, '0);
            chk("R3", "request at threshold", 32'(dma_req), 32'd0);
            dma_gnt = 1'b1;
            @(negedge clk);
            dma_gnt = 1'b0;
            chk("R10", "grant without request", 32'(out_valid), 32'd0);
            send(pkt[tb], 1'b0, '0);
            chk("R3", "request above threshold", 32'(dma_req), 32'd1);

            burst(n);
            nexp = ef ? (tb + 1) / ub : tu;
            chk(ef ? "R5" : "R4", "first burst length", 32'(n), 32'(nexp));
            chk(ef ? "R5" : "R4", "request after first burst", 32'(dma_req), 32'd0);

            for (int i = tb + 1; i < len; i++) send(pkt[i], i == len - 1, st);
            chk("R8", "flush request after end of packet", 32'(dma_req), 32'd1);

            for (int k = 0; k < 8; k++) if (dma_req) burst(n);
            chk("R8", "request after tail drained", 32'(dma_req), 32'd0);

            build_exp(len, b32, big, st);
            chk("R8", "units delivered", 32'(got_q.size()), 32'(exp_q.size()));
            for (int i = 0; i < exp_q.size() && i < got_q.size(); i++) begin
                if (i == exp_q.size() - 1)   chk("R7", "status unit", got_q[i], exp_q[i]);
                else if ((i + 1) * ub > len) chk("R6", "padded unit", got_q[i], exp_q[i]);
                else                         chk("R2", "data unit", got_q[i], exp_q[i]);
            end
        end

        // Block mode re-request: 16-bit, threshold 2 words, 12 bytes held
        apply_cfg(1'b0, 1'b0, 2'd0, 1'b0);
        for (int i = 0; i < 12; i++) send(8'(i + 64), 1'b0, '0);
        burst(n);
        chk("R4", "block burst length", 32'(n), 32'd2);
        chk("R4", "immediate re-request", 32'(dma_req), 32'd1);
        burst(n);
        chk("R4", "second block burst length", 32'(n), 32'd2);
        chk("R4", "no request at threshold", 32'(dma_req), 32'd0);
        chk("R2", "second burst first word", got_q[2], 32'h0000_4544);

        // Empty/fill mode with the same fill level
        apply_cfg(1'b0, 1'b0, 2'd0, 1'b1);
        for (int i = 0; i < 12; i++) send(8'(i + 64), 1'b0, '0);
        burst(n);
        chk("R5", "empty/fill burst length", 32'(n), 32'd6);
        chk("R5", "request after empty/fill burst", 32'(dma_req), 32'd0);

        // Overflow: 32-bit, 33 bytes into 32 bytes of storage
        apply_cfg(1'b1, 1'b0, 2'd3, 1'b1);
        for (int i = 0; i < 32; i++) send(8'(i), 1'b0, '0);
        chk("R9", "no overflow when exactly full", 32'(ovf_flag), 32'd0);
        send(8'hEE, 1'b0, '0);
        chk("R9", "overflow flag set", 32'(ovf_flag), 32'd1);
        burst(n);
        chk("R9", "units after dropped byte", 32'(n), 32'd8);
        for (int r = 0; r < 8 && r < got_q.size(); r++)
            chk("R9", "stored row", got_q[r], {8'(4*r+3), 8'(4*r+2), 8'(4*r+1), 8'(4*r)});
        chk("R9", "dropped byte leaves nothing", 32'(dma_req), 32'd0);
        chk("R9", "overflow flag sticky", 32'(ovf_flag), 32'd1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule